// File: doc/BRIEF.md
# AXI Read Sequence Trigger Capture

This block is the capture engine of an on-chip logic analyzer attached to the read side of an AXI port. Software arms it with a single pulse. From the next clock it stores the probe data word into a circular sample memory on every cycle. At the same time, a three-stage sequencer follows one read transaction. It first waits for a read address request, then for the master to accept read data, and finally for the last beat of the burst. The cycle in which that last beat is seen becomes the trigger sample.

The number of samples kept ahead of the trigger is programmable and is latched when the unit is armed. After the trigger, capture runs until the memory holds one full window, then stops and raises done. A status group reports whether the unit is armed, which sequencer stage is active, and whether the pre-trigger part of the window is full. It also reports the triggered and done flags and how many pre-trigger samples were actually kept. The stored window is read through a random-access port that is rebased so that address 0 is always the oldest kept sample.

The probe inputs are pure observation taps: the block never stalls the monitored bus, so they carry no valid/ready pair and no back-pressure exists on them. The readout port is a plain address/data lookup with no back-pressure either. A new address may be presented every cycle, and its data appears one cycle later.

Top module: `axi_rd_trig_capture`

## Requirements
- R1: The sequencer moves at most one stage per clock. Stage code 0 advances to 1 on a cycle with `mon_arvalid`=1. Stage 1 advances to 2 on a cycle with `mon_rready`=1. Stage 2 fires the trigger on a cycle with `mon_rlast`=1 and goes to code 3. In every other case the stage holds. `stat_stage` reports this code.
- R2: A one-cycle `arm` pulse sets `stat_armed` on the next clock. The same clock returns the stage to 0, clears triggered and done, and restarts the write pointer and pre-trigger count. A pulse during a capture restarts it in the same way.
- R3: The trigger sample is the sample stored on the cycle where `mon_rlast`=1 is seen in stage 2. `stat_triggered` rises on the following clock.
- R4: `cfg_pre` is latched at arm. `stat_pre_full` is 1 exactly while armed and not triggered with the pre-trigger count equal to the latched value.
- R5: After the trigger sample, exactly DEPTH-1-`cfg_pre` further samples are stored. On the clock that stores the last of them, done rises and armed falls. With `cfg_pre`=DEPTH-1, done rises on the trigger clock itself.
- R6: After done, `rd_data` one clock after `rd_addr`=i is window sample i. Sample 0 is the oldest kept sample, and the trigger sample sits at index `stat_pre_count`.
- R7: The pre-trigger count saturates at the latched setting. If the trigger comes earlier, `stat_pre_count` is the number of samples actually stored before it, and the window is that much shorter.
- R8: A synchronous `rst` clears armed, triggered and done, sets the stage to 0 and the pre-trigger count to 0, and overrides `arm`.
- R9: While not armed, the probe inputs have no effect: the stage, the flags and the stored window are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| arm | input | 1 | Start/restart capture pulse |
| cfg_pre | input | AW | Samples to keep before the trigger (0..DEPTH-1), latched at arm |
| mon_arvalid | input | 1 | Probe: read address valid |
| mon_rready | input | 1 | Probe: read data ready |
| mon_rlast | input | 1 | Probe: last read beat |
| mon_data | input | DATA_W | Probe data word stored each armed cycle |
| stat_armed | output | 1 | Capture running |
| stat_stage | output | 2 | Sequencer stage code |
| stat_pre_full | output | 1 | Pre-trigger region full while waiting |
| stat_triggered | output | 1 | Trigger has fired |
| stat_done | output | 1 | Window complete, memory frozen |
| stat_pre_count | output | AW | Pre-trigger samples kept |
| rd_addr | input | AW | Window index to read |
| rd_data | output | DATA_W | Window sample, one cycle after `rd_addr` |

## Verification
The hardest situations to reach are the orderings that must not shortcut the sequence. These include a last beat seen in stage 0 or 1, address valid and read ready arriving in the same cycle, and a trigger that lands before the pre-trigger region has filled, so the rebased window is shorter than the memory. The stimulus drives each of these on purpose: stray `mon_rlast` pulses in early stages, a combined `mon_arvalid`/`mon_rready` cycle, and a back-to-back three-cycle transaction straight after arming. It also covers both extreme positions (0 and DEPTH-1), re-arming and resetting mid-capture, and probe activity while idle or frozen. A behavioural model tracks every stored sample and the status on each clock.

// File: rtl/axi_rd_trig_pkg.sv
package axi_rd_trig_pkg;
  typedef enum logic [1:0] {
    SEQ_ADDR = 2'd0,
    SEQ_DATA = 2'd1,
    SEQ_LAST = 2'd2,
    SEQ_HIT  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/axi_rd_trig_seq.sv
module axi_rd_trig_seq
  import axi_rd_trig_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic       en,
  input  logic       arvalid,
  input  logic       rready,
  input  logic       rlast,
  output seq_state_t state,
  output logic       hit
);
  seq_state_t state_nx;
  logic [1:0] st_bits;

  assign st_bits = state;
  assign hit     = en && !restart && (state == SEQ_LAST) && rlast;

  always_comb begin
    state_nx = state;
    if (restart) begin
      state_nx = SEQ_ADDR;
    end else if (en) begin
      unique case (state)
        SEQ_ADDR: if (arvalid) state_nx = SEQ_DATA;
        SEQ_DATA: if (rready)  state_nx = SEQ_LAST;
        SEQ_LAST: if (rlast)   state_nx = SEQ_HIT;
        default:               state_nx = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= SEQ_ADDR;
    else     state <= state_nx;
  end

  // R1: never skips a stage
  a_r1_single_step: assert property (@(posedge clk) disable iff (rst)
    !restart |=> (st_bits == $past(st_bits) || st_bits == $past(st_bits) + 2'd1));
  // R1: first stage holds without address valid
  a_r1_hold_addr: assert property (@(posedge clk) disable iff (rst)
    (en && !restart && state == SEQ_ADDR && !arvalid) |=> state == SEQ_ADDR);
  // R2: restart returns to stage 0
  a_r2_restart_stage: assert property (@(posedge clk) disable iff (rst)
    restart |=> state == SEQ_ADDR);
endmodule

// File: rtl/axi_rd_trig_ctrl.sv
module axi_rd_trig_ctrl #(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic [AW-1:0] cfg_pre,
  input  logic          hit,
  output logic          armed,
  output logic          triggered,
  output logic          done,
  output logic          pre_full,
  output logic [AW-1:0] pre_cnt,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] base_addr
);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [AW-1:0] wr_ptr, cfg_pos, post_left, trig_addr, post_need;

  assign post_need = LAST_IDX - cfg_pos;
  assign wr_en     = armed;
  assign wr_addr   = wr_ptr;
  assign base_addr = trig_addr - pre_cnt;
  assign pre_full  = armed && !triggered && (pre_cnt == cfg_pos);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b0;
      triggered <= 1'b0;
      done      <= 1'b0;
      wr_ptr    <= '0;
      pre_cnt   <= '0;
      cfg_pos   <= '0;
      post_left <= '0;
      trig_addr <= '0;
    end else if (arm) begin
      armed     <= 1'b1;
      triggered <= 1'b0;
      done      <= 1'b0;
      wr_ptr    <= '0;
      pre_cnt   <= '0;
      cfg_pos   <= cfg_pre;
    end else if (armed) begin
      wr_ptr <= wr_ptr + 1'b1;
      if (!triggered) begin
        if (hit) begin
          triggered <= 1'b1;
          trig_addr <= wr_ptr;
          post_left <= post_need;
          if (post_need == '0) begin
            armed <= 1'b0;
            done  <= 1'b1;
          end
        end else if (pre_cnt != cfg_pos) begin
          pre_cnt <= pre_cnt + 1'b1;
        end
      end else begin
        post_left <= post_left - 1'b1;
        if (post_left == AW'(1)) begin
          armed <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end

  // R2: arm starts a fresh capture
  a_r2_arm_starts: assert property (@(posedge clk) disable iff (rst)
    arm |=> (armed && !triggered && !done && pre_cnt == '0));
  // R3: trigger flag follows the hit
  a_r3_hit_flags: assert property (@(posedge clk) disable iff (rst)
    (hit && !arm && armed && !triggered) |=> triggered);
  // R4: pre-trigger count bounded by setting
  a_r4_pre_bound: assert property (@(posedge clk) disable iff (rst)
    pre_cnt <= cfg_pos);
  // R5: done freezes capture
  a_r5_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !armed);
  // R5: final post sample raises done
  a_r5_post_end: assert property (@(posedge clk) disable iff (rst)
    (armed && triggered && post_left == AW'(1) && !arm) |=> done);
  // R8: reset clears flags
  a_r8_reset_clear: assert property (@(posedge clk)
    rst |=> (!armed && !triggered && !done));
endmodule

// File: rtl/axi_rd_trig_ram.sv
module axi_rd_trig_ram #(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/axi_rd_trig_capture.sv
module axi_rd_trig_capture
  import axi_rd_trig_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic [AW-1:0]     cfg_pre,
  input  logic              mon_arvalid,
  input  logic              mon_rready,
  input  logic              mon_rlast,
  input  logic [DATA_W-1:0] mon_data,
  output logic              stat_armed,
  output logic [1:0]        stat_stage,
  output logic              stat_pre_full,
  output logic              stat_triggered,
  output logic              stat_done,
  output logic [AW-1:0]     stat_pre_count,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  seq_state_t    stage;
  logic          hit, seq_en, wr_en;
  logic [AW-1:0] wr_addr, base_addr, rd_phys;

  assign seq_en     = stat_armed && !stat_triggered;
  assign stat_stage = stage;
  assign rd_phys    = base_addr + rd_addr;

  axi_rd_trig_seq u_seq (
    .clk(clk), .rst(rst), .restart(arm), .en(seq_en),
    .arvalid(mon_arvalid), .rready(mon_rready), .rlast(mon_rlast),
    .state(stage), .hit(hit)
  );

  axi_rd_trig_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .arm(arm), .cfg_pre(cfg_pre), .hit(hit),
    .armed(stat_armed), .triggered(stat_triggered), .done(stat_done),
    .pre_full(stat_pre_full), .pre_cnt(stat_pre_count),
    .wr_en(wr_en), .wr_addr(wr_addr), .base_addr(base_addr)
  );

  axi_rd_trig_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(mon_data),
    .rd_addr(rd_phys), .rd_data(rd_data)
  );

  // R9: stage frozen while idle
  a_r9_idle_stage: assert property (@(posedge clk) disable iff (rst)
    (!stat_armed && !arm) |=> $stable(stat_stage));
endmodule

// File: tb/axi_rd_trig_capture_bench.sv
`timescale 1ns/1ps
module axi_rd_trig_capture_bench;
  localparam int DEPTH = 32;
  localparam int DW = 16;
  localparam int AW = $clog2(DEPTH);

  logic clk = 0, rst = 1, arm = 0;
  logic [AW-1:0] cfg_pre = '0, rd_addr = '0;
  logic av = 0, rr = 0, rl = 0;
  logic [DW-1:0] data = '0;
  logic s_armed, s_pf, s_trig, s_done;
  logic [1:0] s_stage;
  logic [AW-1:0] s_pcnt;
  logic [DW-1:0] rd_data;

  int checks = 0, errors = 0, cyc = 0;
  int m_armed = 0, m_trig = 0, m_done = 0, m_state = 0, m_pre = 0, m_pos = 0, m_left = 0;
  int hist[$];

  always #4 clk = ~clk;

  axi_rd_trig_capture #(.DEPTH(DEPTH), .DATA_W(DW)) u_axi_rd_trig_capture (
    .clk(clk), .rst(rst), .arm(arm), .cfg_pre(cfg_pre),
    .mon_arvalid(av), .mon_rready(rr), .mon_rlast(rl), .mon_data(data),
    .stat_armed(s_armed), .stat_stage(s_stage), .stat_pre_full(s_pf),
    .stat_triggered(s_trig), .stat_done(s_done), .stat_pre_count(s_pcnt),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic model_edge();
    if (rst) begin
      m_armed = 0; m_trig = 0; m_done = 0; m_state = 0; m_pre = 0; m_pos = 0;
      hist.delete();
    end else if (arm) begin
      m_armed = 1; m_trig = 0; m_done = 0; m_state = 0; m_pre = 0;
      m_pos = int'(cfg_pre);
      hist.delete();
    end else if (m_armed == 1) begin
      hist.push_back(int'(data));
      if (m_trig == 0) begin
        if (m_state == 2 && rl) begin
          m_state = 3; m_trig = 1; m_left = DEPTH - 1 - m_pos;
          if (m_left == 0) begin m_armed = 0; m_done = 1; end
        end else begin
          if (m_state == 0 && av) m_state = 1;
          else if (m_state == 1 && rr) m_state = 2;
          if (m_pre < m_pos) m_pre++;
        end
      end else begin
        m_left--;
        if (m_left == 0) begin m_armed = 0; m_done = 1; end
      end
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(s_stage == 2'(m_state), "R1 stage", int'(s_stage), m_state);
    chk(s_armed == m_armed[0], "R2 armed", int'(s_armed), m_armed);
    chk(s_trig == m_trig[0], "R3 triggered", int'(s_trig), m_trig);
    chk(s_pf == (m_armed == 1 && m_trig == 0 && m_pre == m_pos), "R4 pre_full",
        int'(s_pf), int'(m_armed == 1 && m_trig == 0 && m_pre == m_pos));
    chk(s_done == m_done[0], "R5 done", int'(s_done), m_done);
    chk(int'(s_pcnt) == m_pre, "R7 pre_count", int'(s_pcnt), m_pre);
    cyc++;
    data = DW'(cyc * 37 + 5);
  endtask

  task automatic pulse_arm(input int pos);
    cfg_pre = AW'(pos); arm = 1; step(); arm = 0;
  endtask

  task automatic run_to_done();
    for (int i = 0; i < 4 * DEPTH && m_done == 0; i++) step();
  endtask

  // R6: rebased readout of the whole kept window
  task automatic readout(input string tag);
    int n;
    n = m_pre + 1 + (DEPTH - 1 - m_pos);
    chk(m_done == 1 && hist.size() >= n, tag, hist.size(), n);
    for (int i = 0; i < n && i < hist.size(); i++) begin
      rd_addr = AW'(i);
      step();
      chk(int'(rd_data) == hist[hist.size() - n + i], tag, int'(rd_data),
          hist[hist.size() - n + i]);
    end
  endtask

  task automatic txn3();
    av = 1; step(); av = 0;
    rr = 1; step(); rr = 0;
    rl = 1; step(); rl = 0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired cycle %0d actual 0 expected 1", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R8: reset state
    rst = 1; step(); step(); rst = 0; step();
    // R9: probes while idle
    av = 1; rr = 1; rl = 1; repeat (3) step(); av = 0; rr = 0; rl = 0;

    // Scenario A: full pre-trigger, stray rlast, combined arvalid/rready (R1)
    pulse_arm(8);
    repeat (15) step();
    rl = 1; step(); rl = 0;
    av = 1; rr = 1; step(); av = 0; rr = 0;
    repeat (2) step();
    rl = 1; step(); rl = 0;
    rr = 1; step(); rr = 0;
    repeat (3) step();
    rl = 1; step(); rl = 0;
    run_to_done();
    readout("R6 window A");
    // R9: probes after done leave window and status alone
    av = 1; rr = 1; rl = 1; repeat (4) step(); av = 0; rr = 0; rl = 0;
    readout("R9 frozen window A");

    // Scenario B: early trigger (R7)
    pulse_arm(20);
    txn3();
    chk(m_pre == 2, "R7 early count", m_pre, 2);
    run_to_done();
    readout("R7 short window B");

    // Scenario C: position DEPTH-1, done on trigger clock (R5)
    pulse_arm(DEPTH - 1);
    repeat (DEPTH + 5) step();
    txn3();
    chk(int'(s_done) == 1, "R5 immediate done", int'(s_done), 1);
    readout("R6 window C");

    // Scenario D: position 0
    pulse_arm(0);
    repeat (3) step();
    txn3();
    run_to_done();
    readout("R6 window D");

    // Scenario E: re-arm mid capture (R2), reset mid capture (R8)
    pulse_arm(4);
    repeat (10) step();
    av = 1; step(); av = 0;
    rr = 1; step(); rr = 0;
    pulse_arm(6);
    repeat (3) step();
    av = 1; step(); av = 0;
    rst = 1; step(); rst = 0; step();
    pulse_arm(10);
    repeat (12) step();
    txn3();
    run_to_done();
    readout("R2 window after re-arm");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule